// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block is a serial slave that fills a bank of control registers from a three-wire link made of a serial clock, a serial data line and a latch strobe. All three lines are brought into the system clock domain through two-flop synchronizers. After that, rising edges are found by comparing each line with its value one cycle earlier. Every rising edge of the serial clock shifts one data bit into a 32-bit word, most significant bit first.

A rising edge of the latch strobe commits the word. Its lowest 4 bits pick one of 16 registers, and its upper 28 bits become that register's new contents. Downstream logic sees every register in parallel. For each commit it also gets a one-cycle write strobe together with the address and payload that were written.

The system clock must run at least four times as fast as the serial clock. With that margin, serial high and low phases as short as two system cycles are still seen. When programming ends, the lines rest low, and falling edges are never treated as events.

Top module: `cfgser_top`

## Requirements
- R1: Each rising edge of the serial clock appends the current data bit at the low end of the 32-bit shift word. The first bit received therefore ends up at bit 31 (MSB-first order).
- R2: A rising edge of the latch strobe writes word bits [31:4] into the register whose index is word bits [3:0].
- R3: A commit leaves every register other than the addressed one unchanged, and no register changes without a commit.
- R4: Falling edges on any line, and data-line changes with no serial clock edge, neither shift the word nor commit it. The word is kept across a commit, so a second latch pulse writes the same word again.
- R5: Serial clock rising edges that occur while the latch strobe is high are ignored.
- R6: Reset loads each register with its parameter default and clears the shift word. A latch pulse with no clocks after reset therefore writes payload 0 to register 0.
- R7: Each commit raises the write strobe for exactly one system cycle. At the same time, the address and payload outputs carry the values being written.
- R8: Shifting continues past 32 bits with no error, so only the last 32 bits received before the latch edge are used.
- R9: The block operates correctly with serial high and low phases as short as two system clock cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Latch strobe; rising edge commits (asynchronous) |
| regs_o | output | NREG*DATA_W (448) | All register contents, register i at bits [i*28 +: 28] |
| wr_stb_o | output | 1 | One-cycle pulse per commit |
| wr_addr_o | output | ADDR_W (4) | Address of the latest commit |
| wr_data_o | output | DATA_W (28) | Payload of the latest commit |

## Verification
A wrong shift word stays hidden until the next latch edge. Then, about four system cycles later, it shows up as a wrong address or payload on the strobe outputs, and in the wrong slice of the register vector. A faulty commit path instead shows up as a corrupted neighbouring register, a strobe that lasts too long, or a commit on a falling edge. For that reason the bench compares the whole bank after every word. It also commits the retained word a second time after idle line activity and after clocks given while the latch is high.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int unsigned LN_SCLK = 0;
  localparam int unsigned LN_SDAT = 1;
  localparam int unsigned LN_LE   = 2;
  localparam int unsigned N_LINES = 3;

  typedef struct packed {
    logic       sclk_rise;
    logic       le_rise;
    logic       le_lvl;
    logic       dat_lvl;
  } line_ev_t;
endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/cfgser_shifter.sv
module cfgser_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end
endmodule

// File: rtl/cfgser_bank.sv
module cfgser_bank #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned DATA_W   = WORD_W - ADDR_W,
  parameter int unsigned NREG     = 1 << ADDR_W,
  parameter logic [NREG*DATA_W-1:0] DEFAULTS = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic [WORD_W-1:0]      word,
  output logic [NREG*DATA_W-1:0] regs,
  output logic                   stb,
  output logic [ADDR_W-1:0]      addr,
  output logic [DATA_W-1:0]      data
);
  logic [ADDR_W-1:0] sel;
  logic [DATA_W-1:0] pay;
  assign sel = word[ADDR_W-1:0];
  assign pay = word[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g*DATA_W +: DATA_W] <= DEFAULTS[g*DATA_W +: DATA_W];
      else if (commit && sel == ADDR_W'(g))
        regs[g*DATA_W +: DATA_W] <= pay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb  <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      stb <= commit;
      if (commit) begin
        addr <= sel;
        data <= pay;
      end
    end
  end
endmodule

// File: rtl/cfgser_top.sv
module cfgser_top #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned SYNC_STG = 2,
  parameter int unsigned DATA_W   = WORD_W - ADDR_W,
  parameter int unsigned NREG     = 1 << ADDR_W,
  parameter logic [NREG*DATA_W-1:0] DEFAULTS = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  input  logic                   ser_le_i,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   wr_stb_o,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [DATA_W-1:0]      wr_data_o
);
  import cfgser_pkg::*;

  logic [N_LINES-1:0] raw, lvl, rise;
  line_ev_t           ev;
  logic               shift_en;
  logic [WORD_W-1:0]  sr_word;

  always_comb begin
    raw          = '0;
    raw[LN_SCLK] = ser_clk_i;
    raw[LN_SDAT] = ser_dat_i;
    raw[LN_LE]   = ser_le_i;
  end

  cfgser_sync #(.N(N_LINES), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .lvl(lvl), .rise(rise)
  );

  always_comb begin
    ev.sclk_rise = rise[LN_SCLK];
    ev.le_rise   = rise[LN_LE];
    ev.le_lvl    = lvl[LN_LE];
    ev.dat_lvl   = lvl[LN_SDAT];
  end

  assign shift_en = ev.sclk_rise & ~ev.le_lvl;

  cfgser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(ev.dat_lvl), .word(sr_word)
  );

  cfgser_bank #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .NREG(NREG), .DEFAULTS(DEFAULTS)
  ) u_bank (
    .clk(clk), .rst(rst), .commit(ev.le_rise), .word(sr_word),
    .regs(regs_o), .stb(wr_stb_o), .addr(wr_addr_o), .data(wr_data_o)
  );
endmodule

// File: rtl/cfgser_chk.sv
module cfgser_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DATA_W = WORD_W - ADDR_W,
  parameter int unsigned NREG   = 1 << ADDR_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_stb,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [NREG*DATA_W-1:0] regs,
  input logic                   sclk_rise,
  input logic                   le_rise,
  input logic                   le_lvl,
  input logic                   dat_lvl,
  input logic [WORD_W-1:0]      sr
);
  // R7: strobe lasts one cycle
  p_stb_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  // R2: strobed payload sits in the addressed register
  p_reg_match_r2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> regs[wr_addr*DATA_W +: DATA_W] == wr_data);
  // R3: registers change only together with a strobe
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs) |-> wr_stb);
  // R4: a strobe follows only a latch rising edge
  p_commit_src_r4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(le_rise));
  // R5: clock edges while latch high leave the word alone
  p_le_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && le_lvl) |=> $stable(sr));
  // R1: a shift places the data bit at the low end
  p_shift_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !le_lvl) |=> sr[0] == $past(dat_lvl));
  // R6: word cleared after reset
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sr == '0);
endmodule

bind cfgser_top cfgser_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .NREG(NREG)
) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb_o), .wr_addr(wr_addr_o), .wr_data(wr_data_o),
  .regs(regs_o), .sclk_rise(ev.sclk_rise), .le_rise(ev.le_rise), .le_lvl(ev.le_lvl),
  .dat_lvl(ev.dat_lvl), .sr(sr_word)
);

// File: tb/sim_cfgser_top.sv
module sim_cfgser_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int WW = 32;
  localparam int DW = WW - AW;
  localparam int NR = 1 << AW;

  function automatic logic [NR*DW-1:0] mk_def();
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = DW'(i * 28'h0111111 + 28'h0000A5);
    return v;
  endfunction
  localparam logic [NR*DW-1:0] DEF = mk_def();

  logic clk = 0, rst = 1;
  logic sclk = 0, sdat = 0, sle = 0;
  logic [NR*DW-1:0] regs;
  logic wstb;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  cfgser_top #(.ADDR_W(AW), .WORD_W(WW), .DEFAULTS(DEF)) u0 (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
    .regs_o(regs), .wr_stb_o(wstb), .wr_addr_o(waddr), .wr_data_o(wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, stb_cnt = 0, long_stb = 0;
  logic prev_stb = 0;
  logic [AW-1:0] cap_a;
  logic [DW-1:0] cap_d;
  logic [DW-1:0] model [NR];
  bit done = 0;

  always @(negedge clk) begin
    if (!rst && wstb) begin
      stb_cnt++;
      cap_a = waddr;
      cap_d = wdata;
      if (prev_stb) long_stb++;
    end
    prev_stb = wstb;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, input int h);
    sdat = b; cyc(h);
    sclk = 1; cyc(h);
    sclk = 0;
  endtask

  task automatic le_pulse(input int h);
    sle = 1; cyc(h);
    sle = 0; cyc(h + 8);
  endtask

  task automatic send(input logic [WW-1:0] w, input int h);
    for (int i = WW - 1; i >= 0; i--) sbit(w[i], h);
    sdat = 0;
    le_pulse(h);
  endtask

  function automatic logic [WW-1:0] mkw(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {d, a};
  endfunction

  task automatic apply(input logic [WW-1:0] w);
    model[w[AW-1:0]] = w[WW-1:AW];
  endtask

  task automatic chk_bank(input string tag);
    for (int i = 0; i < NR; i++)
      chk(regs[i*DW +: DW] == model[i], tag, 32'(regs[i*DW +: DW]), 32'(model[i]));
  endtask

  task automatic chk_commit(input string tag, input int n0, input logic [WW-1:0] w);
    chk(stb_cnt == n0 + 1, {tag, " strobe count R7"}, 32'(stb_cnt), 32'(n0 + 1));
    chk(cap_a == w[AW-1:0] && cap_d == w[WW-1:AW], {tag, " addr/data R7"},
        {cap_d, cap_a}, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [WW-1:0] w;
    void'($urandom(32'h5EED1));
    for (int i = 0; i < NR; i++) model[i] = DEF[i*DW +: DW];
    cyc(5); rst = 0; cyc(3);

    // R6: reset defaults
    chk_bank("R6 reset defaults");
    chk(stb_cnt == 0, "R6 no strobe after reset", 32'(stb_cnt), 0);
    // R6: cleared word commits zero to register 0
    n0 = stb_cnt; le_pulse(3);
    model[0] = '0;
    chk_commit("R6 cleared word", n0, '0);
    chk_bank("R6 cleared word bank");

    // R1/R2: MSB-first order, top register
    w = mkw(4'hF, 28'h8000001); n0 = stb_cnt; send(w, 3); apply(w);
    chk_commit("R1 msb first", n0, w);
    chk_bank("R2 reg15 R3");
    w = mkw(4'h1, 28'hFFFFFFF); n0 = stb_cnt; send(w, 2); apply(w);
    chk_commit("R2 reg1", n0, w);
    chk_bank("R3 others kept");

    // R4: data toggles and falling edges alone do nothing; word retained
    n0 = stb_cnt;
    sdat = 1; cyc(6); sdat = 0; cyc(6);
    chk(stb_cnt == n0, "R4 no commit from idle lines", 32'(stb_cnt), 32'(n0));
    le_pulse(3);
    chk_commit("R4 retained word", n0, w);
    chk_bank("R4 bank");

    // R5: clocks while latch high ignored
    w = mkw(4'h7, 28'h1234567); n0 = stb_cnt;
    for (int i = WW - 1; i >= 0; i--) sbit(w[i], 2);
    sdat = 1; sle = 1; cyc(4);
    for (int k = 0; k < 5; k++) sbit(1'b1, 2);
    sdat = 0; sle = 0; cyc(12); apply(w);
    chk_commit("R5 first", n0, w);
    n0 = stb_cnt; le_pulse(2);
    chk_commit("R5 clocks under latch ignored", n0, w);
    chk_bank("R5 bank");

    // R8: overlong word keeps last 32 bits
    w = mkw(4'h3, 28'h0ABCDEF); n0 = stb_cnt;
    for (int k = 0; k < 9; k++) sbit(1'b1, 2);
    send(w, 2); apply(w);
    chk_commit("R8 overlong", n0, w);
    chk_bank("R8 bank");

    // R9: random words at random phase lengths down to two cycles
    for (int t = 0; t < 40; t++) begin
      int h;
      h = 2 + int'($urandom_range(3));
      w = $urandom;
      n0 = stb_cnt; send(w, h); apply(w);
      chk_commit("R9 random", n0, w);
    end
    chk_bank("R9 final bank R3");
    chk(long_stb == 0, "R7 strobe width", 32'(long_stb), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule